// File: doc/BRIEF.md
# Serial EEPROM Write Sequencer

This block is a bus master for a two-wire serial EEPROM that uses a two-byte internal address. It takes one write command at a time: a 3-bit device select, a 15-bit memory address and a length of 1 to 64 bytes. It then streams the data bytes in through a valid/ready port and puts the whole write on the bus as one transfer. That transfer is a START, a control byte, the high address byte, the low address byte, the data bytes back to back, and one STOP. The STOP is what makes the device commit its page buffer.

After the STOP the device is busy with its internal write for an unknown time. The block finds the end of that write by acknowledge polling. It sends START, the control byte and STOP again and again, until the device acknowledges the control byte. Only then does it pulse `done`, so a new command can never land on a busy device. If an address or data byte is not acknowledged, the block ends the transfer with a STOP and pulses `err_nack`. If the device is still busy after `POLL_LIMIT` attempts, it pulses `err_timeout`.

The clock and data lines are open-drain. An output of 1 on `scl_oe` or `sda_oe` pulls that line low, and the block reads the data line back on `sda_in`. Every bit is cut into four quarters of `DIV` clock cycles each.

The sequencer FSM has these states: `S_IDLE`, `S_START`, `S_CTRL`, `S_AHI`, `S_ALO`, `S_DATA`, `S_STOP`, `S_ABORT`, `S_PSTART`, `S_PCTRL`, `S_PSTOP`, `S_FIN_OK`, `S_FIN_NACK` and `S_FIN_TMO`. It moves between them as follows:
- `S_IDLE` goes to `S_START` when a command is accepted.
- The write path runs `S_START`→`S_CTRL`→`S_AHI`→`S_ALO`→`S_DATA`.
- `S_DATA` repeats until the last byte, then goes to `S_STOP`.
- An ACK moves the write path on to the next state; a NACK on any byte of it goes to `S_ABORT`, and `S_ABORT` then goes to `S_FIN_NACK`.
- `S_STOP` goes to `S_PSTART`, and polling runs `S_PSTART`→`S_PCTRL`→`S_PSTOP`.
- `S_PSTOP` goes to `S_FIN_OK` if the poll was acknowledged.
- Without an acknowledge, `S_PSTOP` goes back to `S_PSTART`, or to `S_FIN_TMO` once the limit is used up.
- Every `S_FIN_*` state lasts one cycle and returns to `S_IDLE`.

Top module: `eew_master`

## Requirements
- R1: The first byte after each START is the control byte: bits 7..4 = 1010, bits 3..1 = device select, bit 0 = 0 (write). Every byte goes out MSB first.
- R2: In a write transfer the control byte is followed by {0, addr[14:8]} and then addr[7:0]. Bit 7 of the high byte is always 0.
- R3: `cmd_len` + 1 data bytes (1 to 64) follow the address bytes in the order they were accepted on `wr_valid`/`wr_ready`. `wr_ready` is high only while the block is busy. If data arrives late, SCL is held low until the byte comes, and the stream is not changed by the wait.
- R4: SDA changes only while SCL is low, except for the START edge and the STOP edge. Within a transfer, every high pulse of SCL lasts 2·`DIV` clock cycles. Each START is matched by one STOP.
- R5: After a write that was fully acknowledged, the block repeats START, control byte, STOP until the control byte is acknowledged. It then pulses `done`.
- R6: A NACK on the control, address or data byte of a write ends the transfer with a STOP and pulses `err_nack`. No polling follows.
- R7: Polling makes at most `POLL_LIMIT` attempts. An ACK on the last allowed attempt still gives `done`. If no attempt is acknowledged, the block pulses `err_timeout`.
- R8: `busy` is high from the cycle after a command is accepted until the cycle in which exactly one of `done`, `err_nack` or `err_timeout` pulses. `cmd_ready` is high only when the block is idle, and it is high again in the cycle after the pulse.
- R9: After reset and whenever the block is idle, both lines are released, `busy` is low and `cmd_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Command accepted when high with `cmd_valid` |
| cmd_sel | input | 3 | Device select bits |
| cmd_addr | input | 15 | Memory address of the first byte |
| cmd_len | input | 6 | Number of data bytes minus one |
| wr_valid | input | 1 | Data byte offered |
| wr_ready | output | 1 | Data byte taken when high with `wr_valid` |
| wr_data | input | 8 | Data byte |
| scl_oe | output | 1 | 1 pulls SCL low |
| sda_oe | output | 1 | 1 pulls SDA low |
| sda_in | input | 1 | Level read back from SDA |
| busy | output | 1 | Command in progress |
| done | output | 1 | One-cycle pulse: write finished and committed |
| err_nack | output | 1 | One-cycle pulse: write aborted on a NACK |
| err_timeout | output | 1 | One-cycle pulse: polling limit used up |

## Verification
Two decisions can fall on the same acknowledge slot.

The first pair is the end of the data count and a NACK. The bench NACKs exactly the last data byte and expects an abort with `err_nack`, with no polling at all. It also NACKs the first and a middle data byte, both address bytes and the control byte.

The second pair is the end of the poll budget and an ACK. The bench sweeps the number of busy NACKs from 0 to `POLL_LIMIT`+1. An ACK that arrives on attempt `POLL_LIMIT` must give `done` after exactly `POLL_LIMIT` attempts, and one busy NACK more must give `err_timeout` after the same number of attempts.

A bus model built from the two lines is the judge. It counts every byte, START and STOP, and the width of every SCL high pulse.

// File: rtl/eew_pkg.sv
package eew_pkg;

    localparam int BYTE_BITS = 8;          // bit index BYTE_BITS is the ack slot
    localparam logic [3:0] DEV_CODE = 4'b1010;

    typedef enum logic [1:0] {
        OP_START,
        OP_STOP,
        OP_BYTE
    } op_t;

    typedef enum logic [1:0] {
        P_IDLE,
        P_START,
        P_STOP,
        P_BYTE
    } ph_t;

    typedef enum logic [3:0] {
        S_IDLE,
        S_START,
        S_CTRL,
        S_AHI,
        S_ALO,
        S_DATA,
        S_STOP,
        S_ABORT,
        S_PSTART,
        S_PCTRL,
        S_PSTOP,
        S_FIN_OK,
        S_FIN_NACK,
        S_FIN_TMO
    } st_t;

endpackage

// File: rtl/eew_tick.sv
module eew_tick #(
    parameter int DIV = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sync,
    output logic tick
);
    localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;
    localparam logic [CW-1:0] LAST = CW'(DIV - 1);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt <= '0;
        else if (sync || cnt == LAST)
            cnt <= '0;
        else
            cnt <= cnt + 1'b1;
    end

    assign tick = (cnt == LAST);
endmodule

// File: rtl/eew_phy.sv
module eew_phy
    import eew_pkg::*;
#(
    parameter int DIV = 4
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       op_valid,
    input  op_t        op_kind,
    input  logic [7:0] op_byte,
    output logic       op_ready,
    output logic       op_done,
    output logic       op_ack,
    input  logic       sda_in,
    output logic       scl_oe,
    output logic       sda_oe
);
    localparam logic [3:0] ACK_SLOT = 4'(BYTE_BITS);

    ph_t        pst;
    logic [1:0] q;
    logic [3:0] bitn;
    logic [7:0] shreg;
    logic       tick, accept;
    logic       want_scl, want_sda;

    assign op_ready = (pst == P_IDLE);
    assign accept   = op_valid && op_ready;

    eew_tick #(.DIV(DIV)) u_tick (
        .clk  (clk),
        .rst_n(rst_n),
        .sync (accept),
        .tick (tick)
    );

    // phase state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pst     <= P_IDLE;
            q       <= '0;
            bitn    <= '0;
            shreg   <= '0;
            op_ack  <= 1'b0;
            op_done <= 1'b0;
        end else begin
            op_done <= 1'b0;
            if (pst == P_IDLE) begin
                if (op_valid) begin
                    unique case (op_kind)
                        OP_START: pst <= P_START;
                        OP_STOP:  pst <= P_STOP;
                        default:  pst <= P_BYTE;
                    endcase
                    q     <= '0;
                    bitn  <= '0;
                    shreg <= op_byte;
                end
            end else if (tick) begin
                if (pst == P_BYTE && q == 2'd1 && bitn == ACK_SLOT)
                    op_ack <= ~sda_in;
                if (q == 2'd3) begin
                    q <= '0;
                    if (pst == P_BYTE && bitn != ACK_SLOT) begin
                        bitn  <= bitn + 1'b1;
                        shreg <= {shreg[6:0], 1'b0};
                    end else begin
                        pst     <= P_IDLE;
                        op_done <= 1'b1;
                    end
                end else begin
                    q <= q + 1'b1;
                end
            end
        end
    end

    // line levels per quarter (1 = pull low)
    always_comb begin
        want_scl = scl_oe;
        want_sda = sda_oe;
        unique case (pst)
            P_START: begin
                want_scl = (q == 2'd0) || (q == 2'd3);
                want_sda = (q >= 2'd2);
            end
            P_STOP: begin
                want_scl = (q == 2'd0);
                want_sda = (q <= 2'd1);
            end
            P_BYTE: begin
                want_scl = (q == 2'd0) || (q == 2'd3);
                want_sda = (bitn == ACK_SLOT) ? 1'b0 : ~shreg[7];
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_oe <= 1'b0;
            sda_oe <= 1'b0;
        end else if (pst != P_IDLE) begin
            scl_oe <= want_scl;
            sda_oe <= want_sda;
        end
    end
endmodule

// File: rtl/eew_master.sv
module eew_master
    import eew_pkg::*;
#(
    parameter int DIV        = 4,
    parameter int MAX_BYTES  = 64,
    parameter int POLL_LIMIT = 16
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         cmd_valid,
    output logic                         cmd_ready,
    input  logic [2:0]                   cmd_sel,
    input  logic [14:0]                  cmd_addr,
    input  logic [$clog2(MAX_BYTES)-1:0] cmd_len,
    input  logic                         wr_valid,
    output logic                         wr_ready,
    input  logic [7:0]                   wr_data,
    output logic                         scl_oe,
    output logic                         sda_oe,
    input  logic                         sda_in,
    output logic                         busy,
    output logic                         done,
    output logic                         err_nack,
    output logic                         err_timeout
);
    localparam int LW = $clog2(MAX_BYTES);
    localparam int PW = $clog2(POLL_LIMIT + 1);
    localparam logic [PW-1:0] LAST_POLL = PW'(POLL_LIMIT - 1);

    st_t         st;
    logic        waiting;
    logic [2:0]  sel_q;
    logic [14:0] addr_q;
    logic [LW-1:0] cnt_q;
    logic [PW-1:0] polls;
    logic        poll_ack;

    logic        op_valid, op_ready, op_done, op_ack;
    op_t         op_kind;
    logic [7:0]  op_byte;
    logic [7:0]  ctrl_byte;
    logic        fin;

    assign ctrl_byte = {DEV_CODE, sel_q, 1'b0};
    assign fin       = waiting && op_done;

    eew_phy #(.DIV(DIV)) u_phy (
        .clk     (clk),
        .rst_n   (rst_n),
        .op_valid(op_valid),
        .op_kind (op_kind),
        .op_byte (op_byte),
        .op_ready(op_ready),
        .op_done (op_done),
        .op_ack  (op_ack),
        .sda_in  (sda_in),
        .scl_oe  (scl_oe),
        .sda_oe  (sda_oe)
    );

    // state register and sequencing data
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st       <= S_IDLE;
            waiting  <= 1'b0;
            sel_q    <= '0;
            addr_q   <= '0;
            cnt_q    <= '0;
            polls    <= '0;
            poll_ack <= 1'b0;
        end else begin
            if (op_valid && op_ready)
                waiting <= 1'b1;
            else if (op_done)
                waiting <= 1'b0;

            unique case (st)
                S_IDLE: if (cmd_valid) begin
                    sel_q  <= cmd_sel;
                    addr_q <= cmd_addr;
                    cnt_q  <= cmd_len;
                    st     <= S_START;
                end
                S_START:  if (fin) st <= S_CTRL;
                S_CTRL:   if (fin) st <= op_ack ? S_AHI : S_ABORT;
                S_AHI:    if (fin) st <= op_ack ? S_ALO : S_ABORT;
                S_ALO:    if (fin) st <= op_ack ? S_DATA : S_ABORT;
                S_DATA: if (fin) begin
                    if (!op_ack)          st <= S_ABORT;
                    else if (cnt_q == '0) st <= S_STOP;
                    else                  cnt_q <= cnt_q - 1'b1;
                end
                S_STOP: if (fin) begin
                    polls <= '0;
                    st    <= S_PSTART;
                end
                S_ABORT:  if (fin) st <= S_FIN_NACK;
                S_PSTART: if (fin) st <= S_PCTRL;
                S_PCTRL: if (fin) begin
                    poll_ack <= op_ack;
                    st       <= S_PSTOP;
                end
                S_PSTOP: if (fin) begin
                    if (poll_ack)                st <= S_FIN_OK;
                    else if (polls == LAST_POLL) st <= S_FIN_TMO;
                    else begin
                        polls <= polls + 1'b1;
                        st    <= S_PSTART;
                    end
                end
                default: st <= S_IDLE;
            endcase
        end
    end

    // outputs and bus operation requests
    always_comb begin
        op_valid    = 1'b0;
        op_kind     = OP_BYTE;
        op_byte     = 8'h00;
        wr_ready    = 1'b0;
        cmd_ready   = (st == S_IDLE);
        done        = (st == S_FIN_OK);
        err_nack    = (st == S_FIN_NACK);
        err_timeout = (st == S_FIN_TMO);
        busy        = 1'b1;
        unique case (st)
            S_IDLE, S_FIN_OK, S_FIN_NACK, S_FIN_TMO: busy = 1'b0;
            S_START, S_PSTART: begin
                op_kind  = OP_START;
                op_valid = !waiting;
            end
            S_STOP, S_ABORT, S_PSTOP: begin
                op_kind  = OP_STOP;
                op_valid = !waiting;
            end
            S_CTRL, S_PCTRL: begin
                op_byte  = ctrl_byte;
                op_valid = !waiting;
            end
            S_AHI: begin
                op_byte  = {1'b0, addr_q[14:8]};
                op_valid = !waiting;
            end
            S_ALO: begin
                op_byte  = addr_q[7:0];
                op_valid = !waiting;
            end
            S_DATA: begin
                op_byte  = wr_data;
                op_valid = !waiting && wr_valid;
                wr_ready = !waiting && op_ready;
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/eew_master_chk.sv
module eew_master_chk (
    input logic clk,
    input logic rst_n,
    input logic cmd_valid,
    input logic cmd_ready,
    input logic wr_ready,
    input logic scl_oe,
    input logic sda_oe,
    input logic busy,
    input logic done,
    input logic err_nack,
    input logic err_timeout
);
    a_r8_single_outcome: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({done, err_nack, err_timeout}));

    a_r8_busy_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_ready) |=> busy);

    a_r8_busy_ends_with_outcome: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> (done || err_nack || err_timeout));

    a_r8_ready_after_outcome: assert property (@(posedge clk) disable iff (!rst_n)
        (done || err_nack || err_timeout) |=> cmd_ready);

    a_r9_idle_lines_released: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_ready |-> (!scl_oe && !sda_oe && !busy));

    a_r3_data_only_when_busy: assert property (@(posedge clk) disable iff (!rst_n)
        wr_ready |-> busy);
endmodule

bind eew_master eew_master_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .cmd_valid  (cmd_valid),
    .cmd_ready  (cmd_ready),
    .wr_ready   (wr_ready),
    .scl_oe     (scl_oe),
    .sda_oe     (sda_oe),
    .busy       (busy),
    .done       (done),
    .err_nack   (err_nack),
    .err_timeout(err_timeout)
);

// File: tb/eew_master_test.sv
`timescale 1ns/1ps
module eew_master_test;
    localparam int DIV   = 2;
    localparam int MAXB  = 64;
    localparam int PLIM  = 4;
    localparam int LW    = $clog2(MAXB);

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #5 clk = ~clk;

    logic          cmd_valid = 1'b0;
    logic          cmd_ready;
    logic [2:0]    cmd_sel = '0;
    logic [14:0]   cmd_addr = '0;
    logic [LW-1:0] cmd_len = '0;
    logic          wr_valid = 1'b0;
    logic          wr_ready;
    logic [7:0]    wr_data = '0;
    logic          scl_oe, sda_oe, sda_in;
    logic          busy, done, err_nack, err_timeout;

    logic s_pull = 1'b0;
    wire  scl = ~scl_oe;
    wire  sda = ~(sda_oe | s_pull);
    assign sda_in = sda;

    eew_master #(.DIV(DIV), .MAX_BYTES(MAXB), .POLL_LIMIT(PLIM)) uut (
        .clk(clk), .rst_n(rst_n),
        .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
        .cmd_sel(cmd_sel), .cmd_addr(cmd_addr), .cmd_len(cmd_len),
        .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_data(wr_data),
        .scl_oe(scl_oe), .sda_oe(sda_oe), .sda_in(sda_in),
        .busy(busy), .done(done), .err_nack(err_nack), .err_timeout(err_timeout)
    );

    int vectors = 0;
    int miscompares = 0;
    bit finished = 1'b0;

    task automatic chk(input bit ok, input string tag, input string what,
                       input int got, input int exp);
        vectors++;
        if (!ok) begin
            miscompares++;
            $display("FAIL %s %s: got %0d expected %0d", tag, what, got, exp);
        end
    endtask

    // ---------------- EEPROM bus model ----------------
    int  dev_strap = 0;
    int  busy_set = 0;
    int  busy_left = 0;
    int  nack_at = 999;
    int  log_b[200];
    int  log_n = 0;
    int  txn_cnt = 0;
    int  stop_cnt = 0;
    int  scl_bad = 0;
    bit  in_txn = 1'b0;
    bit  wrote = 1'b0;
    int  bitc = 0;
    int  byte_idx = 0;
    logic [7:0] shr = '0;
    time t_rise = 0;

    always @(negedge sda) if (scl === 1'b1) begin
        in_txn = 1'b1; bitc = 0; byte_idx = 0; txn_cnt++;
    end

    always @(posedge sda) if (scl === 1'b1 && in_txn) begin
        in_txn = 1'b0; stop_cnt++;
        if (wrote) busy_left = busy_set;
        wrote = 1'b0;
    end

    always @(posedge scl) begin
        t_rise = $time;
        if (in_txn && bitc < 8) begin
            shr = {shr[6:0], sda};
            bitc++;
        end
    end

    always @(negedge scl) if (in_txn) begin
        if ($time - t_rise != time'(2 * DIV * 10)) scl_bad++;
        if (bitc == 8) begin
            bit ack;
            if (log_n < 200) log_b[log_n] = int'(shr);
            log_n++;
            if (byte_idx == 0) begin
                ack = (shr[7:1] == {4'b1010, 3'(dev_strap)}) && !shr[0] && busy_left == 0;
                if (busy_left > 0) busy_left--;
            end else begin
                ack = 1'b1;
            end
            if (txn_cnt == 1 && byte_idx == nack_at) ack = 1'b0;
            if (ack && byte_idx >= 3) wrote = 1'b1;
            s_pull = ack;
            bitc = 9;
        end else if (bitc == 9) begin
            s_pull = 1'b0;
            bitc = 0;
            byte_idx++;
        end
    end

    // ---------------- data feeder ----------------
    int feed_i = 0;
    int feed_n = 0;
    int feed_seed = 0;
    bit feed_gap = 1'b0;
    int cyc = 0;

    function automatic logic [7:0] data_of(input int i, input int seed);
        return 8'((i * 73 + seed * 11 + 5) & 255);
    endfunction

    always @(posedge clk) if (wr_valid && wr_ready) feed_i <= feed_i + 1;

    always @(negedge clk) begin
        cyc++;
        wr_valid = (feed_i < feed_n) && !(feed_gap && (cyc % 5) < 2);
        wr_data  = data_of(feed_i, feed_seed);
    end

    // ---------------- one command ----------------
    task automatic run_cmd(input int sel, input int strap, input int addr, input int n,
                           input int busy_n, input int nack_i, input bit gap, input int seed);
        int expb[200];
        int exp_n = 0;
        int eff, polls, exp_txn, exp_out, got_out, waitc;
        logic [7:0] ctrl;
        bit saw_busy;
        ctrl = {4'b1010, 3'(sel), 1'b0};
        eff = (strap != sel) ? 0 : nack_i;
        if (eff < 3 + n) begin
            for (int k = 0; k <= eff; k++) begin
                if (k == 0)      expb[exp_n] = int'(ctrl);
                else if (k == 1) expb[exp_n] = (addr >> 8) & 8'h7f;
                else if (k == 2) expb[exp_n] = addr & 8'hff;
                else             expb[exp_n] = int'(data_of(k - 3, seed));
                exp_n++;
            end
            exp_out = 2; exp_txn = 1;
        end else begin
            expb[0] = int'(ctrl);
            expb[1] = (addr >> 8) & 8'h7f;
            expb[2] = addr & 8'hff;
            exp_n = 3;
            for (int k = 0; k < n; k++) begin expb[exp_n] = int'(data_of(k, seed)); exp_n++; end
            polls = (busy_n < PLIM) ? busy_n + 1 : PLIM;
            for (int k = 0; k < polls; k++) begin expb[exp_n] = int'(ctrl); exp_n++; end
            exp_out = (busy_n < PLIM) ? 1 : 3;
            exp_txn = 1 + polls;
        end

        @(negedge clk);
        dev_strap = strap; busy_set = busy_n; busy_left = 0; nack_at = nack_i;
        log_n = 0; txn_cnt = 0; stop_cnt = 0; scl_bad = 0; wrote = 1'b0;
        feed_i = 0; feed_n = n; feed_seed = seed; feed_gap = gap;
        cmd_sel = 3'(sel); cmd_addr = 15'(addr); cmd_len = LW'(n - 1);
        cmd_valid = 1'b1;
        while (!cmd_ready) @(negedge clk);
        @(posedge clk);
        @(negedge clk);
        cmd_valid = 1'b0;
        saw_busy = busy && !cmd_ready;
        chk(saw_busy, "R8", "busy high and cmd_ready low after accept", int'(busy), 1);

        got_out = 0; waitc = 0;
        while (got_out == 0 && waitc < 30000) begin
            if (done) got_out = 1;
            else if (err_nack) got_out = 2;
            else if (err_timeout) got_out = 3;
            else begin
                if (!busy) begin saw_busy = 1'b0; end
                @(negedge clk); waitc++;
            end
        end
        chk(saw_busy, "R8", "busy held until outcome", int'(saw_busy), 1);
        chk(got_out == exp_out, (exp_out == 2) ? "R6" : ((exp_out == 3) ? "R7" : "R5"),
            "outcome (1 done, 2 nack, 3 timeout)", got_out, exp_out);
        chk(!busy, "R8", "busy low in outcome cycle", int'(busy), 0);
        @(negedge clk);
        feed_n = 0;
        chk(cmd_ready && !done && !err_nack && !err_timeout, "R8",
            "ready and single pulse after outcome", int'(cmd_ready), 1);
        chk(!scl_oe && !sda_oe, "R9", "lines released when idle",
            int'({scl_oe, sda_oe}), 0);
        chk(log_n == exp_n, "R5", "bytes seen on bus", log_n, exp_n);
        for (int k = 0; k < exp_n && k < log_n; k++)
            chk(log_b[k] == expb[k],
                (k == 0 || k >= 3 + n) ? "R1" : ((k < 3) ? "R2" : "R3"),
                $sformatf("bus byte %0d", k), log_b[k], expb[k]);
        chk(txn_cnt == exp_txn, (exp_out == 2) ? "R6" : "R5", "START count", txn_cnt, exp_txn);
        chk(stop_cnt == txn_cnt, "R4", "STOP count", stop_cnt, txn_cnt);
        chk(scl_bad == 0, "R4", "SCL high pulses of wrong width", scl_bad, 0);
    endtask

    // ---------------- watchdog ----------------
    initial begin
        repeat (190000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            vectors++; miscompares++;
            $display("FAIL watchdog: got 0 expected 1 (run completed)");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    end

    // ---------------- main sequence ----------------
    initial begin
        repeat (3) @(negedge clk);
        chk(!scl_oe && !sda_oe, "R9", "lines released in reset", int'({scl_oe, sda_oe}), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(cmd_ready && !busy && !done && !err_nack && !err_timeout, "R9",
            "idle after reset", int'({cmd_ready, busy}), 2);

        // R3 / R1 / R2: length sweep with select and address varied, some with stalls
        for (int n = 1; n <= 8; n++)
            run_cmd(n % 8, n % 8, (n * 4111) & 16'h7fff, n, 1, 999, n[0], n);
        run_cmd(5, 5, 15'h7fff, 16, 0, 999, 1'b1, 21);
        run_cmd(2, 2, 15'h0000, 63, 2, 999, 1'b0, 22);
        run_cmd(7, 7, 15'h4a5b, 64, 1, 999, 1'b1, 23);

        // R2: address extremes, high bit of the high byte forced to zero
        run_cmd(0, 0, 15'h7fff, 1, 0, 999, 1'b0, 30);
        run_cmd(1, 1, 15'h0000, 1, 0, 999, 1'b0, 31);

        // R5 / R7: busy sweep across the poll limit
        for (int b = 0; b <= PLIM + 1; b++)
            run_cmd(3, 3, 15'h1234 + b, 2, b, 999, 1'b0, 40 + b);

        // R6: NACK at every byte of a 3-byte write, last data byte included
        run_cmd(6, 2, 15'h0abc, 3, 0, 999, 1'b0, 50);
        for (int k = 0; k <= 5; k++)
            run_cmd(4, 4, 15'h0abc + k, 3, 0, k, k[0], 51 + k);

        // back to normal after errors
        run_cmd(2, 2, 15'h2222, 4, 1, 999, 1'b0, 60);

        if (!finished) begin
            finished = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    end
endmodule